// File: doc/BRIEF.md
# TLB Maintenance Register Unit

This unit is the register face of a software-managed translation buffer. It holds an entry index, the current process identifier and a zone-protection word. It also owns the tag, data and entry-ID arrays of the buffer. Software reaches the entry picked by the index through two window registers, one for the data word and one for the tag word. Writing a search register runs a tag-match lookup over all entries. On a hit the lookup leaves the matching index in the index register. On a miss it raises a flag bit there.

Access is gated by two configuration inputs: an MMU mode and an access level. The unit drives a one-cycle global flush pulse when the zone word changes. It drives a per-entry flush pulse, carrying the entry number, whenever a tag is rewritten. Downstream translation caches use these pulses to drop stale copies.

Register codes on `regAddr`: 0 index, 1 data window, 2 tag window, 3 process ID, 4 zone word, 5 search. Codes 6 and 7 are unused.

Top module: `mmu_regif`

## Requirements
- R1: After reset every register and every array word reads 0, and neither flush output is high.
- R2: Reads return data on `rdData` in the cycle after the request, and `rdData` holds its value until the next accepted read. The data window (code 1) reads and writes the data word of entry `index[IDX_W-1:0]`, and the upper index bits are ignored for selection. A write to code 0 replaces all 32 bits of the index register.
- R3: A write to the tag window (code 2) stores the written word as the entry's tag. It also stores `pid[7:0]` as that entry's ID. In the next cycle `entryFlush` is high for one cycle, with `entryFlushIdx` equal to the entry number.
- R4: A read of the tag window returns the entry's tag and loads the process-ID register with the entry's ID, zero-extended.
- R5: A write to the search register (code 5) looks for the lowest-numbered matching entry. On a hit, the index register becomes that entry number. An entry matches under three conditions. First, tag bit 6 (valid) is set. Second, the page size is 1 KiB << (2*f), where f is tag bits [9:7], and address bits 31 down to 10+2f of the written word equal those of the tag. Third, the entry ID is 0 or equals `pid[7:0]`.
- R6: A search with no matching entry sets bit 31 of the index register and leaves bits 30:0 unchanged.
- R7: When `cfgMode` is below 2 or `cfgLevel` is 0, every read returns 0 and every write is ignored.
- R8: Reads of codes 1, 2, 3 and 4 need `cfgLevel` bit 0. Without it they return 0, and a tag read then leaves the process ID unchanged. The index register reads with any nonzero level.
- R9: Writes to codes 3, 4 and 5 need `cfgLevel` of 2 or 3. At level 1 they are ignored.
- R10: A zone write whose value differs from the stored word makes `flushAll` high for one cycle in the next cycle. A write of the same value raises no pulse.
- R11: When `wrEn` and `rdEn` are high in the same cycle, only the write is performed and `rdData` keeps its previous value.
- R12: Codes 6 and 7, and reads of the search register, return 0. Writes to codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | MMU mode; 2 or 3 means full mode |
| cfgLevel | input | 2 | Register access level |
| wrEn | input | 1 | Register write request |
| rdEn | input | 1 | Register read request |
| regAddr | input | 3 | Register code |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Read value, one cycle after the request |
| flushAll | output | 1 | One-cycle pulse after a zone-word change |
| entryFlush | output | 1 | One-cycle pulse after a tag write |
| entryFlushIdx | output | IDX_W (4) | Entry number for `entryFlush` |

## Verification
The search is tried with four kinds of entries:
- Entries that share a page with different indices show that the lowest index wins.
- Large-page entries, probed just inside and just outside their span, show that the size field widens the compare.
- Entry IDs that equal, differ from or are zero relative to the current PID show the ID filter.
- Invalid entries that carry a matching page show that the valid bit is honoured.

Random traffic mixes all register codes under varied mode and level settings against a bench model. That separates the gating paths from the window side effects on the process ID and the index.

// File: rtl/mmu_regif_pkg.sv
package mmu_regif_pkg;

  localparam int WORD_W    = 32;
  localparam int TID_W     = 8;
  localparam int PAGE_LSB  = 10;
  localparam int VALID_BIT = 6;
  localparam int SIZE_LSB  = 7;
  localparam int SIZE_W    = 3;
  localparam int MISS_BIT  = 31;

  typedef enum logic [2:0] {
    RA_INDEX  = 3'd0,
    RA_DATA   = 3'd1,
    RA_TAG    = 3'd2,
    RA_PID    = 3'd3,
    RA_ZONE   = 3'd4,
    RA_SEARCH = 3'd5
  } regAddrE;

  typedef struct packed {
    logic wrIndex;
    logic wrData;
    logic wrTag;
    logic wrPid;
    logic wrZone;
    logic wrSearch;
    logic rdIndex;
    logic rdData;
    logic rdTag;
    logic rdPid;
    logic rdZone;
    logic rdDeny;
  } strobeT;

endpackage

// File: rtl/mmu_tag_search.sv
module mmu_tag_search
  import mmu_regif_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tagVec,
  input  logic [NUM_ENTRIES-1:0][TID_W-1:0]  tidVec,
  input  logic [TID_W-1:0]                   pidLow,
  input  logic [WORD_W-1:0]                  key,
  output logic                               hit,
  output logic [IDX_W-1:0]                   hitIdx
);

  logic [NUM_ENTRIES-1:0] match;

  // Compare mask for a size code: bits at and above the page boundary.
  function automatic logic [WORD_W-1:0] pageMask(input logic [SIZE_W-1:0] sizeCode);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = (b >= PAGE_LSB + 2 * int'(sizeCode));
    end
    return m;
  endfunction

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [SIZE_W-1:0] sizeCode;
    logic              pageEq;
    logic              idOk;
    assign sizeCode = tagVec[g][SIZE_LSB +: SIZE_W];
    assign pageEq   = ((key ^ tagVec[g]) & pageMask(sizeCode)) == '0;
    assign idOk     = (tidVec[g] == '0) || (tidVec[g] == pidLow);
    assign match[g] = tagVec[g][VALID_BIT] && pageEq && idOk;
  end

  always_comb begin
    hit    = |match;
    hitIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hitIdx = IDX_W'(i);
    end
  end

  // R5: a reported hit always points at a valid entry
  always_comb begin
    if (hit) begin
      a_r5_hit_is_valid: assert (tagVec[hitIdx][VALID_BIT]);
    end
  end

endmodule

// File: rtl/mmu_regif_ctrl.sv
module mmu_regif_ctrl
  import mmu_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic [1:0] cfgLevel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] regAddr,
  output strobeT     strb
);

  logic unitOn;
  logic privWr;
  logic rdOk;
  logic doWr;
  logic doRd;

  assign unitOn = (cfgMode >= 2'd2) && (cfgLevel != 2'd0);
  assign privWr = cfgLevel[1];
  assign rdOk   = cfgLevel[0];
  assign doWr   = wrEn && unitOn;
  assign doRd   = rdEn && !wrEn;

  always_comb begin
    strb = '0;
    if (doWr) begin
      case (regAddr)
        RA_INDEX:  strb.wrIndex  = 1'b1;
        RA_DATA:   strb.wrData   = 1'b1;
        RA_TAG:    strb.wrTag    = 1'b1;
        RA_PID:    strb.wrPid    = privWr;
        RA_ZONE:   strb.wrZone   = privWr;
        RA_SEARCH: strb.wrSearch = privWr;
        default:   ;
      endcase
    end
    if (doRd) begin
      if (!unitOn) begin
        strb.rdDeny = 1'b1;
      end else begin
        case (regAddr)
          RA_INDEX: strb.rdIndex = 1'b1;
          RA_DATA:  begin strb.rdData = rdOk; strb.rdDeny = !rdOk; end
          RA_TAG:   begin strb.rdTag  = rdOk; strb.rdDeny = !rdOk; end
          RA_PID:   begin strb.rdPid  = rdOk; strb.rdDeny = !rdOk; end
          RA_ZONE:  begin strb.rdZone = rdOk; strb.rdDeny = !rdOk; end
          default:  strb.rdDeny = 1'b1;
        endcase
      end
    end
  end

  // R11: a read request alongside a write produces no read strobe
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |-> !(strb.rdIndex || strb.rdData || strb.rdTag ||
                         strb.rdPid || strb.rdZone || strb.rdDeny));

  // R9: privileged writes never strobe below level 2
  a_r9_priv_gate: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !cfgLevel[1]) |-> !(strb.wrPid || strb.wrZone || strb.wrSearch));

  // R7: nothing is written when the unit is switched off
  a_r7_off_no_write: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode < 2'd2) || (cfgLevel == 2'd0)) |-> !(strb.wrIndex || strb.wrData || strb.wrTag));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/mmu_regif_dp.sv
module mmu_regif_dp
  import mmu_regif_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              flushAll,
  output logic              entryFlush,
  output logic [IDX_W-1:0]  entryFlushIdx
);

  logic [WORD_W-1:0]                  indexReg;
  logic [WORD_W-1:0]                  pidReg;
  logic [WORD_W-1:0]                  zoneReg;
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] tagArr;
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] dataArr;
  logic [NUM_ENTRIES-1:0][TID_W-1:0]  tidArr;
  logic [WORD_W-1:0]                  rdReg;
  logic                               flushAllQ;
  logic                               entryFlushQ;
  logic [IDX_W-1:0]                   entryFlushIdxQ;

  logic [IDX_W-1:0] sel;
  logic             searchHit;
  logic [IDX_W-1:0] searchIdx;

  assign sel = indexReg[IDX_W-1:0];

  mmu_tag_search #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) i_search (
    .tagVec(tagArr),
    .tidVec(tidArr),
    .pidLow(pidReg[TID_W-1:0]),
    .key   (wrData),
    .hit   (searchHit),
    .hitIdx(searchIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg       <= '0;
      pidReg         <= '0;
      zoneReg        <= '0;
      tagArr         <= '0;
      dataArr        <= '0;
      tidArr         <= '0;
      rdReg          <= '0;
      flushAllQ      <= 1'b0;
      entryFlushQ    <= 1'b0;
      entryFlushIdxQ <= '0;
    end else begin
      flushAllQ   <= strb.wrZone && (wrData != zoneReg);
      entryFlushQ <= strb.wrTag;
      if (strb.wrTag) entryFlushIdxQ <= sel;

      if (strb.wrIndex) indexReg <= wrData;
      if (strb.wrSearch) begin
        if (searchHit) indexReg <= WORD_W'(searchIdx);
        else           indexReg[MISS_BIT] <= 1'b1;
      end

      if (strb.wrData) dataArr[sel] <= wrData;
      if (strb.wrTag) begin
        tagArr[sel] <= wrData;
        tidArr[sel] <= pidReg[TID_W-1:0];
      end

      if (strb.wrPid && (wrData != pidReg)) pidReg <= wrData;
      if (strb.rdTag) pidReg <= WORD_W'(tidArr[sel]);
      if (strb.wrZone) zoneReg <= wrData;

      if (strb.rdDeny)       rdReg <= '0;
      else if (strb.rdIndex) rdReg <= indexReg;
      else if (strb.rdData)  rdReg <= dataArr[sel];
      else if (strb.rdTag)   rdReg <= tagArr[sel];
      else if (strb.rdPid)   rdReg <= pidReg;
      else if (strb.rdZone)  rdReg <= zoneReg;
    end
  end

  assign rdData        = rdReg;
  assign flushAll      = flushAllQ;
  assign entryFlush    = entryFlushQ;
  assign entryFlushIdx = entryFlushIdxQ;

  a_r6_miss_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSearch && !searchHit) |=>
      (indexReg[MISS_BIT] && (indexReg[MISS_BIT-1:0] == $past(indexReg[MISS_BIT-1:0]))));

  a_r5_hit_index: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSearch && searchHit) |=> (indexReg == WORD_W'($past(searchIdx))));

  a_r3_entry_flush: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTag |=> (entryFlush && (entryFlushIdx == $past(sel))));

  a_r4_pid_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdTag |=> (pidReg == WORD_W'($past(tidArr[sel]))));

  a_r10_flush_cause: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> $past(strb.wrZone));

  a_r7_deny_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdDeny |=> (rdData == '0));

endmodule

// File: rtl/mmu_regif.sv
module mmu_regif
  import mmu_regif_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgLevel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              flushAll,
  output logic              entryFlush,
  output logic [IDX_W-1:0]  entryFlushIdx
);

  strobeT strb;

  mmu_regif_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgMode (cfgMode),
    .cfgLevel(cfgLevel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  mmu_regif_dp #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .rdData       (rdData),
    .flushAll     (flushAll),
    .entryFlush   (entryFlush),
    .entryFlushIdx(entryFlushIdx)
  );

endmodule

// File: tb/test_mmu_regif.sv
module test_mmu_regif;

  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd2;
  logic [1:0]  cfgLevel = 2'd3;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        flushAll;
  logic        entryFlush;
  logic [IW-1:0] entryFlushIdx;

  always #10 clk = ~clk;

  mmu_regif #(.NUM_ENTRIES(N)) i_mmu_regif (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgLevel(cfgLevel),
    .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .flushAll(flushAll), .entryFlush(entryFlush),
    .entryFlushIdx(entryFlushIdx)
  );

  logic [31:0] mTag [N];
  logic [31:0] mData[N];
  logic [7:0]  mTid [N];
  logic [31:0] mIdx, mPid, mZone, mRd;
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pmask(input int f);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (b >= 10 + 2 * f);
    return m;
  endfunction

  function automatic int lookup(input logic [31:0] key);
    for (int i = 0; i < N; i++) begin
      if (mTag[i][6] && (((key ^ mTag[i]) & pmask(int'(mTag[i][9:7]))) == 0) &&
          (mTid[i] == 8'd0 || mTid[i] == mPid[7:0]))
        return i;
    end
    return -1;
  endfunction

  // Performs one request; called at a falling edge, returns at the next one.
  task automatic op(input bit w, input bit r, input logic [2:0] a,
                    input logic [31:0] d, input string req);
    bit en, priv, rok, expFa, expEf;
    int s, l;
    logic [IW-1:0] expEfi;
    en = (cfgMode >= 2) && (cfgLevel != 0);
    priv = cfgLevel[1];
    rok = cfgLevel[0];
    s = int'(mIdx[IW-1:0]);
    expFa = 0; expEf = 0; expEfi = '0;
    if (r && !w) begin
      if (!en) mRd = 0;
      else case (a)
        3'd0: mRd = mIdx;
        3'd1: mRd = rok ? mData[s] : 0;
        3'd2: begin mRd = rok ? mTag[s] : 0; if (rok) mPid = {24'd0, mTid[s]}; end
        3'd3: mRd = rok ? mPid : 0;
        3'd4: mRd = rok ? mZone : 0;
        default: mRd = 0;
      endcase
    end
    if (w && en) begin
      case (a)
        3'd0: mIdx = d;
        3'd1: mData[s] = d;
        3'd2: begin mTag[s] = d; mTid[s] = mPid[7:0]; expEf = 1; expEfi = IW'(s); end
        3'd3: if (priv) mPid = d;
        3'd4: if (priv) begin expFa = (d != mZone); mZone = d; end
        3'd5: if (priv) begin
                l = lookup(d);
                if (l >= 0) mIdx = l; else mIdx[31] = 1'b1;
              end
        default: ;
      endcase
    end
    wrEn = w; rdEn = r; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    check(req, rdData, mRd);
    check(req, {31'd0, flushAll}, {31'd0, expFa});
    check(req, {31'd0, entryFlush}, {31'd0, expEf});
    if (expEf) check(req, {{(32-IW){1'b0}}, entryFlushIdx}, {{(32-IW){1'b0}}, expEfi});
  endtask

  function automatic string reqFor(input bit w, input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2 random";
      3'd2: return w ? "R3 random" : "R4 random";
      3'd3: return "R9 random";
      3'd4: return "R10 random";
      3'd5: return w ? "R5/R6 random" : "R12 random";
      default: return "R12 random";
    endcase
  endfunction

  function automatic logic [31:0] pickPage();
    case ($urandom % 4)
      0: return 32'h0040_0000;
      1: return 32'h0080_0000;
      2: return 32'h1200_0000;
      default: return 32'hA000_0000;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mTag[i] = 0; mData[i] = 0; mTid[i] = 0; end
    mIdx = 0; mPid = 0; mZone = 0; mRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) op(0, 1, 3'(a), 0, "R1 reset");
    op(1, 0, 3'd0, 32'd9, "R1 index set");
    op(0, 1, 3'd2, 0, "R1 tag reset");
    op(0, 1, 3'd1, 0, "R1 data reset");

    // R2: window selection uses low index bits
    op(1, 0, 3'd0, 32'h0000_0013, "R2 index");
    op(1, 0, 3'd1, 32'hCAFE_0003, "R2 data write");
    op(1, 0, 3'd0, 32'h0000_0003, "R2 index");
    op(0, 1, 3'd1, 0, "R2 data read");
    op(0, 1, 3'd0, 0, "R2 index read");

    // R3 / R4: entry ID capture and PID load
    op(1, 0, 3'd3, 32'h0000_01A5, "R3 pid");
    op(1, 0, 3'd2, 32'h0040_0040, "R3 tag write");
    op(1, 0, 3'd3, 32'h0000_0000, "R4 pid clear");
    op(0, 1, 3'd2, 0, "R4 tag read");
    op(0, 1, 3'd3, 0, "R4 pid after tag read");

    // R5: lowest index wins, size field, ID filter
    op(1, 0, 3'd0, 32'd2, "R5 setup");
    op(1, 0, 3'd2, 32'h0040_0040, "R5 tag2");
    op(1, 0, 3'd0, 32'd5, "R5 setup");
    op(1, 0, 3'd2, 32'h0040_0040, "R5 tag5");
    op(1, 0, 3'd0, 32'd7, "R5 setup");
    op(1, 0, 3'd2, 32'h1200_03C0, "R5 tag7 16MiB");
    op(1, 0, 3'd5, 32'h0040_0123, "R5 lowest hit");
    op(0, 1, 3'd0, 0, "R5 index after hit");
    op(1, 0, 3'd5, 32'h12FF_F000, "R5 large page hit");
    op(0, 1, 3'd0, 0, "R5 index after large hit");
    op(1, 0, 3'd0, 32'd5, "R6 setup");
    op(1, 0, 3'd5, 32'h1300_0000, "R6 outside large page");
    op(0, 1, 3'd0, 0, "R6 miss flag");
    op(1, 0, 3'd0, 32'd9, "R5 setup");
    op(1, 0, 3'd3, 32'h0000_0033, "R5 pid");
    op(1, 0, 3'd2, 32'h7700_0040, "R5 tag with ID 33");
    op(1, 0, 3'd3, 32'h0000_0044, "R5 pid other");
    op(1, 0, 3'd5, 32'h7700_0000, "R6 ID mismatch");
    op(0, 1, 3'd0, 0, "R6 index after ID mismatch");
    op(1, 0, 3'd3, 32'h0000_0033, "R5 pid match");
    op(1, 0, 3'd5, 32'h7700_0000, "R5 ID match");
    op(0, 1, 3'd0, 0, "R5 index after ID match");

    // R7: gated off
    cfgMode = 2'd1;
    op(1, 0, 3'd1, 32'h1111_1111, "R7 write ignored");
    op(0, 1, 3'd0, 0, "R7 read zero");
    cfgMode = 2'd2; cfgLevel = 2'd0;
    op(1, 0, 3'd0, 32'd1, "R7 level0 write");
    op(0, 1, 3'd0, 0, "R7 level0 read");
    cfgLevel = 2'd3;
    op(0, 1, 3'd1, 0, "R7 readback");
    op(0, 1, 3'd0, 0, "R7 index readback");

    // R8: reads need level bit 0
    cfgLevel = 2'd2;
    op(0, 1, 3'd1, 0, "R8 data read denied");
    op(0, 1, 3'd2, 0, "R8 tag read denied");
    op(0, 1, 3'd0, 0, "R8 index read");
    cfgLevel = 2'd3;
    op(0, 1, 3'd3, 0, "R8 pid untouched");

    // R9: privileged writes
    cfgLevel = 2'd1;
    op(1, 0, 3'd3, 32'h0000_0055, "R9 pid");
    op(1, 0, 3'd4, 32'h0000_0F0F, "R9 zone");
    op(1, 0, 3'd5, 32'h0040_0000, "R9 search");
    cfgLevel = 2'd3;
    op(0, 1, 3'd3, 0, "R9 pid readback");
    op(0, 1, 3'd4, 0, "R9 zone readback");
    op(0, 1, 3'd0, 0, "R9 index readback");

    // R10: zone flush
    op(1, 0, 3'd4, 32'h8000_0001, "R10 new zone");
    op(1, 0, 3'd4, 32'h8000_0001, "R10 same zone");
    op(0, 1, 3'd4, 0, "R10 zone readback");

    // R11: write and read together
    op(0, 1, 3'd4, 0, "R11 prime");
    op(1, 1, 3'd0, 32'd4, "R11 both");
    op(0, 1, 3'd0, 0, "R11 index readback");

    // R12: unused codes
    op(1, 0, 3'd6, 32'hFFFF_FFFF, "R12 write unused");
    op(1, 0, 3'd7, 32'hFFFF_FFFF, "R12 write unused");
    op(0, 1, 3'd6, 0, "R12 read unused");
    op(0, 1, 3'd7, 0, "R12 read unused");
    op(0, 1, 3'd5, 0, "R12 search read");

    // Random traffic
    for (int k = 0; k < 2000; k++) begin
      bit w, r;
      logic [2:0] a;
      logic [31:0] d;
      int c;
      c = $urandom % 16;
      cfgMode  = (c == 0) ? 2'($urandom % 2) : 2'd2 + 2'($urandom % 2);
      cfgLevel = (c < 3) ? 2'($urandom % 3) : 2'd3;
      a = 3'($urandom % 8);
      w = ($urandom % 2) == 1;
      r = !w || (($urandom % 16) == 0);
      case (a)
        3'd0: d = ($urandom % 8 == 0) ? {1'b1, 31'($urandom % 32)} : 32'($urandom % N);
        3'd2: d = pickPage() | {16'd0, 6'($urandom), 10'd0} | (($urandom % 4 != 0) ? 32'h40 : 32'h0)
                  | {22'd0, 3'($urandom % 8), 7'd0};
        3'd3: d = 32'($urandom % 3);
        3'd4: d = 32'($urandom % 4);
        3'd5: d = pickPage() | 32'($urandom % 32'h0010_0000);
        default: d = $urandom;
      endcase
      op(w, r, a, d, reqFor(w, a));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule